// File: doc/BRIEF.md
# SPI port status word

This block holds the status word of a serial peripheral port. The shift engine sends it one-cycle event strobes: a word transfer has begun, a word transfer has ended, another device has claimed the bus while this port was master, and a transmit collision. The register bus sends it strobes for a write into the transmit buffer, a read out of the receive buffer, and a write to the status address together with its data. From these strobes the block keeps the occupancy of both data buffers, a finished flag for the current word, and four sticky error flags. It drives the assembled 16-bit word continuously so the bus read mux can return it.

Each error flag is set by its own protocol condition and stays set until software writes a 1 to its bit position. A set condition that arrives in the same cycle as a clearing write wins, so no error is lost. The buffer flags have no software write path; they follow only the fill and drain events of the buffers. The serial shifting, the clocks, the chip selects and the data buffers themselves live elsewhere.

Top module: `spi_stat_word`

## Requirements
- R1: After reset the word reads 0x0001, and bits 15 to 7 read as zero at all times.
- R2: Bit 0 (finished) is set by `xferEnd` and cleared by `xferStart`. When both arrive in the same cycle the bit ends up 0.
- R3: Bit 3 (transmit buffer full) is set by `txWrite` and cleared by `xferStart`. When both arrive in the same cycle the bit ends up 1.
- R4: Bit 5 (receive buffer full) is set by `xferEnd` and cleared by `rxRead`. When both arrive in the same cycle the bit ends up 1.
- R5: Bit 2 (transmission error) is set when `xferStart` arrives while bit 3 reads 0.
- R6: Bit 4 (reception error) is set when `xferEnd` arrives while bit 5 reads 1 and `rxRead` is low in that cycle.
- R7: Bit 1 (mode fault) is set when `modeFault` arrives while `isMaster` is high. With `isMaster` low the strobe has no effect.
- R8: Bit 6 (transmit collision) is set when `collision` arrives.
- R9: With `statWrite` high, a 1 in `wrData` at bit 1, 2, 4 or 6 clears that flag, and a 0 leaves it unchanged.
- R10: When a set condition and a clearing write hit the same sticky bit in one cycle, the bit ends up 1.
- R11: `statWrite` never changes bits 0, 3 or 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xferStart | input | 1 | Shift engine loaded the transmit buffer and began a word |
| xferEnd | input | 1 | Shift engine finished a word and moved it into the receive buffer |
| modeFault | input | 1 | Another device drove the port's select line |
| isMaster | input | 1 | Port is currently configured as master |
| collision | input | 1 | Transmit data changed during a shift |
| txWrite | input | 1 | Bus write into the transmit buffer |
| rxRead | input | 1 | Bus read of the receive buffer |
| statWrite | input | 1 | Bus write to the status address |
| wrData | input | 16 | Data of the status write |
| statWord | output | 16 | Current status word |

## Verification
The hardest cases are the coincidences: a clearing write that lands in the same cycle as the condition that sets the same flag, a start and an end of a word together, and a receive-buffer read that races the end of a word while the buffer is already full. The reception-error case needs the receive buffer held full first, so the stimulus biases reads to be rare and ends of words to be frequent, while writes to the status address carry random masks so that clears meet sets often. A directed opening covers reset, a lone mode-fault strobe with and without master mode, and writes of zero, before a long random run compared bit by bit against the bench model on every clock.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int FIN_POS = 0;
  localparam int MF_POS  = 1;
  localparam int TXE_POS = 2;
  localparam int TXF_POS = 3;
  localparam int RXE_POS = 4;
  localparam int RXF_POS = 5;
  localparam int COL_POS = 6;
  localparam int USED_BITS  = 7;
  localparam int NUM_STICKY = 4;

  // sticky index: 0 mode fault, 1 transmit error, 2 receive error, 3 collision
  function automatic int stickyPos(input int idx);
    case (idx)
      0: stickyPos = MF_POS;
      1: stickyPos = TXE_POS;
      2: stickyPos = RXE_POS;
      default: stickyPos = COL_POS;
    endcase
  endfunction

  typedef struct packed {
    logic finSet;
    logic finClr;
    logic txSet;
    logic txClr;
    logic rxSet;
    logic rxClr;
    logic [NUM_STICKY-1:0] errSet;
    logic [NUM_STICKY-1:0] errClr;
  } statStrobes_t;

endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              xferStart,
  input  logic              xferEnd,
  input  logic              modeFault,
  input  logic              isMaster,
  input  logic              collision,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] wrData,
  input  logic              txFullNow,
  input  logic              rxFullNow,
  output statStrobes_t      strobes
);

  logic [NUM_STICKY-1:0] rawSet;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_comb begin
    rawSet[0] = modeFault & isMaster;
    rawSet[1] = xferStart & ~txFullNow;
    rawSet[2] = xferEnd & rxFullNow & ~rxRead;
    rawSet[3] = collision;
  end

  generate
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_errStrobe
      assign strobes.errSet[i] = rawSet[i];
      assign strobes.errClr[i] = statWrite & wrData[stickyPos(i)];
    end
  endgenerate

  assign strobes.finSet = xferEnd;
  assign strobes.finClr = xferStart;
  assign strobes.txSet  = txWrite;
  assign strobes.txClr  = xferStart;
  assign strobes.rxSet  = xferEnd;
  assign strobes.rxClr  = rxRead;

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  statStrobes_t      strobes,
  output logic              txFullNow,
  output logic              rxFullNow,
  output logic [STAT_W-1:0] statWord
);

  logic finReg;
  logic txReg;
  logic rxReg;
  logic [NUM_STICKY-1:0] errReg;

  // start of a new word beats the end of the previous one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                finReg <= 1'b1;
    else if (strobes.finClr)   finReg <= 1'b0;
    else if (strobes.finSet)   finReg <= 1'b1;
  end

  // a refill in the loading cycle leaves the buffer full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                txReg <= 1'b0;
    else if (strobes.txSet)    txReg <= 1'b1;
    else if (strobes.txClr)    txReg <= 1'b0;
  end

  // a new word beats a read of the old one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rxReg <= 1'b0;
    else if (strobes.rxSet)    rxReg <= 1'b1;
    else if (strobes.rxClr)    rxReg <= 1'b0;
  end

  generate
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   errReg[i] <= 1'b0;
        else if (strobes.errSet[i])   errReg[i] <= 1'b1;
        else if (strobes.errClr[i])   errReg[i] <= 1'b0;
      end
    end
  endgenerate

  assign txFullNow = txReg;
  assign rxFullNow = rxReg;

  always_comb begin
    statWord = '0;
    statWord[FIN_POS] = finReg;
    statWord[TXF_POS] = txReg;
    statWord[RXF_POS] = rxReg;
    for (int i = 0; i < NUM_STICKY; i++) begin
      statWord[stickyPos(i)] = errReg[i];
    end
  end

endmodule

// File: rtl/spi_stat_word.sv
module spi_stat_word
  import spi_stat_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xferStart,
  input  logic              xferEnd,
  input  logic              modeFault,
  input  logic              isMaster,
  input  logic              collision,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statWord
);

  statStrobes_t strobes;
  logic txFullNow;
  logic rxFullNow;

  spi_stat_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .xferStart (xferStart),
    .xferEnd   (xferEnd),
    .modeFault (modeFault),
    .isMaster  (isMaster),
    .collision (collision),
    .txWrite   (txWrite),
    .rxRead    (rxRead),
    .statWrite (statWrite),
    .wrData    (wrData),
    .txFullNow (txFullNow),
    .rxFullNow (rxFullNow),
    .strobes   (strobes)
  );

  spi_stat_dp #(.STAT_W(STAT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .txFullNow (txFullNow),
    .rxFullNow (rxFullNow),
    .statWord  (statWord)
  );

endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xferStart,
  input logic              xferEnd,
  input logic              modeFault,
  input logic              isMaster,
  input logic              collision,
  input logic              txWrite,
  input logic              rxRead,
  input logic              statWrite,
  input logic [STAT_W-1:0] wrData,
  input logic [STAT_W-1:0] statWord
);

  always_comb begin
    if (rst_n) assert_upper_zero_R1: assert (statWord[STAT_W-1:7] == '0);
  end

  assert_start_clears_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xferStart |=> !statWord[0]);

  assert_write_fills_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txWrite |=> statWord[3]);

  assert_end_fills_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xferEnd |=> statWord[5]);

  assert_underrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xferStart && !statWord[3]) |=> statWord[2]);

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xferEnd && statWord[5] && !rxRead) |=> statWord[4]);

  assert_slave_fault_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!statWord[1] && !(modeFault && isMaster)) |=> !statWord[1]);

  assert_collision_flag_R8_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> statWord[6]);

  assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (statWrite && wrData[6] && !collision) |=> !statWord[6]);

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (statWord[4] && !(statWrite && wrData[4])) |=> statWord[4]);

  assert_ro_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (statWrite && !xferStart && !xferEnd && !txWrite && !rxRead)
      |=> $stable({statWord[0], statWord[3], statWord[5]}));

endmodule

bind spi_stat_word spi_stat_chk #(.STAT_W(STAT_W)) chk (.*);

// File: tb/tb_spi_stat_word.sv
`timescale 1ns/1ps
module tb_spi_stat_word;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xferStart = 0, xferEnd = 0, modeFault = 0, isMaster = 0, collision = 0;
  logic txWrite = 0, rxRead = 0, statWrite = 0;
  logic [15:0] wrData = '0;
  logic [15:0] statWord;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state, one bit per field
  bit fin = 1, tx = 0, rx = 0, mf = 0, txe = 0, rxe = 0, col = 0;

  always #2.5 clk = ~clk;

  spi_stat_word dut (
    .clk(clk), .rst_n(rst_n), .xferStart(xferStart), .xferEnd(xferEnd),
    .modeFault(modeFault), .isMaster(isMaster), .collision(collision),
    .txWrite(txWrite), .rxRead(rxRead), .statWrite(statWrite),
    .wrData(wrData), .statWord(statWord)
  );

  function automatic logic [15:0] modelWord();
    logic [15:0] w;
    w = 16'h0000;
    if (fin) w = w | 16'h0001;
    if (mf)  w = w | 16'h0002;
    if (txe) w = w | 16'h0004;
    if (tx)  w = w | 16'h0008;
    if (rxe) w = w | 16'h0010;
    if (rx)  w = w | 16'h0020;
    if (col) w = w | 16'h0040;
    return w;
  endfunction

  function automatic string tagOf(int b);
    case (b)
      0: return "R2/R11";
      1: return "R7/R9/R10";
      2: return "R5/R9/R10";
      3: return "R3/R11";
      4: return "R6/R9/R10";
      5: return "R4/R11";
      6: return "R8/R9/R10";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    bit oldTx, oldRx;
    if (!rst_n) begin
      fin = 1; tx = 0; rx = 0; mf = 0; txe = 0; rxe = 0; col = 0;
    end else begin
      oldTx = tx; oldRx = rx;
      if (xferStart) fin = 0; else if (xferEnd) fin = 1;
      if (txWrite) tx = 1; else if (xferStart) tx = 0;
      if (xferEnd) rx = 1; else if (rxRead) rx = 0;
      if (modeFault && isMaster) mf = 1; else if (statWrite && wrData[1]) mf = 0;
      if (xferStart && !oldTx) txe = 1; else if (statWrite && wrData[2]) txe = 0;
      if (xferEnd && oldRx && !rxRead) rxe = 1; else if (statWrite && wrData[4]) rxe = 0;
      if (collision) col = 1; else if (statWrite && wrData[6]) col = 0;
    end
  end

  // compare every bit on the falling edge
  always @(negedge clk) begin
    logic [15:0] exp;
    if (!done) begin
      exp = modelWord();
      for (int b = 0; b < 16; b++) begin
        checks++;
        if (statWord[b] !== exp[b]) begin
          fails++;
          $display("FAIL %s bit %0d: actual %b expected %b (word %h vs %h)",
                   tagOf(b), b, statWord[b], exp[b], statWord, exp);
        end
      end
    end
  end

  task automatic idle();
    xferStart = 0; xferEnd = 0; modeFault = 0; collision = 0;
    txWrite = 0; rxRead = 0; statWrite = 0; wrData = '0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    idle();
    step(3);
    // R1: reset value checked explicitly
    checks++;
    if (statWord !== 16'h0001) begin
      fails++;
      $display("FAIL R1 reset word: actual %h expected 0001", statWord);
    end
    rst_n = 1;
    step(1);
    // R7: fault without master mode is ignored
    modeFault = 1; isMaster = 0; step(1); idle(); step(1);
    modeFault = 1; isMaster = 1; step(1); idle(); step(1);
    // R9: zero write keeps it, one write clears it
    statWrite = 1; wrData = 16'hFFBD; step(1); idle(); step(1);
    statWrite = 1; wrData = 16'h0002; step(1); idle(); step(1);
    // R5 underrun, R3 fill, R2/R4 end, R6 overrun, R10 set beats clear
    xferStart = 1; step(1); idle();
    txWrite = 1; step(1); idle();
    xferEnd = 1; step(1); idle();
    xferStart = 1; xferEnd = 1; txWrite = 1; step(1); idle();
    xferEnd = 1; collision = 1; statWrite = 1; wrData = 16'hFFFF; step(1); idle();
    step(2);
    // random run with biased strobes
    for (int i = 0; i < 4000; i++) begin
      xferStart = ($urandom_range(0, 3) == 0);
      xferEnd   = ($urandom_range(0, 2) == 0);
      rxRead    = ($urandom_range(0, 5) == 0);
      txWrite   = ($urandom_range(0, 3) == 0);
      modeFault = ($urandom_range(0, 7) == 0);
      isMaster  = ($urandom_range(0, 1) == 0);
      collision = ($urandom_range(0, 7) == 0);
      statWrite = ($urandom_range(0, 2) == 0);
      wrData    = 16'($urandom());
      if (i == 2000) rst_n = 0;
      if (i == 2003) rst_n = 1;
      step(1);
    end
    idle();
    step(2);
    finish();
  end

endmodule